// File: doc/BRIEF.md
# Threshold-Driven Byte FIFO Pair

This block holds the two byte queues that sit between a processor and a serial bus engine. Received bytes enter from the engine and leave through an 8-bit processor data port. Bytes to send enter through that same port and leave towards the engine. Both queues have the same depth, which is fixed at build time by a 2-bit size code. The depth is eight shifted left by that code.

Each direction has a programmable threshold. The threshold is stored as its value minus one. A *ready* event fires when a full threshold's worth of bytes can be moved in one burst. A separate *drain* event covers the short remainder at the end of a transfer. That remainder is smaller than the threshold, and software reads the exact amount from the status word. The engine supplies a count of bytes the transfer still has to move on the bus. Ready events can be forwarded as DMA requests, and each direction has its own enable for this.

A configuration word holds the thresholds, the DMA enables and two self-clearing flush bits. A status word reports the size code and both fill levels. A push into a full receive queue raises a one-cycle overrun pulse. A pop from an empty transmit queue raises a one-cycle underflow pulse.

Top module: `fifo_pair_thr`

## Requirements
- R1: Depth is 8 << SIZE_CODE. The status word carries SIZE_CODE in bits 15:14, the receive fill level in bits 13:7 and the transmit fill level in bits 6:0. After reset it reads SIZE_CODE<<14.
- R2: The configuration word has this layout: bit 15 enables receive DMA, bits 13:8 hold the receive threshold minus one, bit 7 enables transmit DMA and bits 5:0 hold the transmit threshold minus one. Readback returns these fields, with bits 14 and 6 always reading 0. The word resets to 0.
- R3: Both queues are first-in first-out. A processor read of an empty receive queue returns 0 and leaves the levels unchanged. A processor write to a full transmit queue is discarded.
- R4: The receive threshold is the field value plus one, limited to the depth. rx_ready is high while the receive level is at least that threshold.
- R5: rx_drain is high while xfer_left is 0 and the receive level is nonzero but below the threshold.
- R6: need is defined as xfer_left minus the transmit level, with a floor of 0. free is the depth minus the transmit level. tx_ready is high while both free and need are at least the transmit threshold.
- R7: tx_drain is high while need is nonzero, need is below the threshold, and free is at least need.
- R8: rx_dma_req equals rx_ready AND the receive DMA enable. tx_dma_req equals tx_ready AND the transmit DMA enable.
- R9: Writing the configuration word with bit 14 set empties the receive queue at that clock edge. Bit 6 does the same for the transmit queue. A flush wins over a push in the same cycle.
- R10: An engine push while the receive queue is full drops the byte. rx_overrun is then high for exactly the next cycle.
- R11: An engine pop while the transmit queue is empty sees eng_tx_data = 0. tx_underflow is then high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word write value |
| cfg_rdata | output | 16 | Configuration word readback |
| stat_rdata | output | 16 | Size code and fill levels |
| cpu_wr | input | 1 | Processor push into transmit queue |
| cpu_wdata | input | 8 | Byte written by processor |
| cpu_rd | input | 1 | Processor pop from receive queue |
| cpu_rdata | output | 8 | Receive queue head, 0 when empty |
| eng_rx_push | input | 1 | Engine push into receive queue |
| eng_rx_data | input | 8 | Byte from engine |
| eng_tx_pop | input | 1 | Engine pop from transmit queue |
| eng_tx_data | output | 8 | Transmit queue head, 0 when empty |
| xfer_left | input | CW | Bytes the transfer still has to move on the bus |
| rx_ready | output | 1 | Receive threshold reached |
| rx_drain | output | 1 | Final receive residue waiting |
| tx_ready | output | 1 | Room and demand for a transmit burst |
| tx_drain | output | 1 | Final transmit residue may be written |
| rx_dma_req | output | 1 | Gated receive DMA request |
| tx_dma_req | output | 1 | Gated transmit DMA request |
| rx_overrun | output | 1 | Pulse: push into full receive queue |
| tx_underflow | output | 1 | Pulse: pop from empty transmit queue |

## Verification
The assertions take for granted that xfer_left changes only between bursts. They also take for granted that the engine and the processor never hold a strobe for more than one cycle per byte. They do not assume that the engine respects full or empty: overrun and underflow pulses are checked precisely when it does not. The stimulus drives each strobe for exactly one clock. It changes xfer_left only through dedicated steps, and it provokes full and empty misuse only in the directed corner tests.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
    localparam int THR_W       = 6;
    localparam int LVL_FIELD_W = 7;

    // configuration word bit positions (software-visible contract)
    localparam int CFG_RX_DMA   = 15;
    localparam int CFG_RX_FLUSH = 14;
    localparam int CFG_RX_THR   = 8;
    localparam int CFG_TX_DMA   = 7;
    localparam int CFG_TX_FLUSH = 6;
    localparam int CFG_TX_THR   = 0;

    typedef struct packed {
        logic             rx_dma;
        logic [THR_W-1:0] rx_thr_m1;
        logic             tx_dma;
        logic [THR_W-1:0] tx_thr_m1;
    } cfg_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          push_lost,
    output logic          pop_lost
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] cnt;
    } ptr_t;

    ptr_t          st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          push_ok, pop_ok;

    assign full      = (st_q.cnt == LW'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign push_ok   = push && !full && !flush;
    assign pop_ok    = pop && !empty && !flush;
    assign push_lost = push && full;
    assign pop_lost  = pop && empty;
    assign level     = st_q.cnt;
    assign rdata     = empty ? '0 : mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = st_q.wp + AW'(1);
            if (pop_ok)  st_d.rp = st_q.rp + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + LW'(1);
                2'b01:   st_d.cnt = st_q.cnt - LW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= wdata;
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LW'(DEPTH)); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R9
    AST_FULL_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full); // R10
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty); // R11
endmodule

// File: rtl/level_flags.sv
module level_flags #(
    parameter  int DEPTH = 16,
    parameter  bit IS_TX = 1'b0,
    parameter  int CW    = 16,
    parameter  int THR_W = 6,
    localparam int LW    = $clog2(DEPTH) + 1,
    localparam int XW    = ((CW > LW) ? CW : LW) + 1
) (
    input  logic [LW-1:0]    level,
    input  logic [THR_W-1:0] thr_m1,
    input  logic [CW-1:0]    left,
    output logic             ready,
    output logic             drain
);
    logic [XW-1:0] lvl, thr_raw, thr;

    assign lvl     = XW'(level);
    assign thr_raw = XW'(thr_m1) + XW'(1);
    assign thr     = (thr_raw > XW'(DEPTH)) ? XW'(DEPTH) : thr_raw;

    generate
        if (IS_TX) begin : g_tx
            logic [XW-1:0] free, need;
            assign free  = XW'(DEPTH) - lvl;
            assign need  = (XW'(left) > lvl) ? (XW'(left) - lvl) : '0;
            assign ready = (free >= thr) && (need >= thr);
            assign drain = !ready && (need != '0) && (need < thr) && (free >= need);
        end else begin : g_rx
            assign ready = (lvl >= thr);
            assign drain = !ready && (lvl != '0) && (left == '0);
        end
    endgenerate
endmodule

// File: rtl/fifo_pair_thr.sv
module fifo_pair_thr
    import fifo_pair_pkg::*;
#(
    parameter  int SIZE_CODE = 1,
    parameter  int CW        = 16,
    localparam int DEPTH     = 8 << SIZE_CODE,
    localparam int LW        = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_rdata,
    output logic [15:0]   stat_rdata,
    input  logic          cpu_wr,
    input  logic [7:0]    cpu_wdata,
    input  logic          cpu_rd,
    output logic [7:0]    cpu_rdata,
    input  logic          eng_rx_push,
    input  logic [7:0]    eng_rx_data,
    input  logic          eng_tx_pop,
    output logic [7:0]    eng_tx_data,
    input  logic [CW-1:0] xfer_left,
    output logic          rx_ready,
    output logic          rx_drain,
    output logic          tx_ready,
    output logic          tx_drain,
    output logic          rx_dma_req,
    output logic          tx_dma_req,
    output logic          rx_overrun,
    output logic          tx_underflow
);
    localparam logic [1:0] SZ = 2'(SIZE_CODE);

    typedef struct packed {
        cfg_t cfg;
        logic ovr;
        logic udf;
    } top_t;

    top_t          st_q, st_d;
    logic          rx_flush, tx_flush;
    logic [LW-1:0] rx_level, tx_level;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic          rx_push_lost, rx_pop_lost, tx_push_lost, tx_pop_lost;
    logic          unused_lost;

    assign rx_flush    = cfg_wr && cfg_wdata[CFG_RX_FLUSH];
    assign tx_flush    = cfg_wr && cfg_wdata[CFG_TX_FLUSH];
    assign unused_lost = rx_pop_lost ^ tx_push_lost ^ rx_empty;

    byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(cpu_rd), .rdata(cpu_rdata),
        .level(rx_level), .full(rx_full), .empty(rx_empty),
        .push_lost(rx_push_lost), .pop_lost(rx_pop_lost)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(cpu_wr), .wdata(cpu_wdata),
        .pop(eng_tx_pop), .rdata(eng_tx_data),
        .level(tx_level), .full(tx_full), .empty(tx_empty),
        .push_lost(tx_push_lost), .pop_lost(tx_pop_lost)
    );

    level_flags #(.DEPTH(DEPTH), .IS_TX(1'b0), .CW(CW), .THR_W(THR_W)) u_rxf (
        .level(rx_level), .thr_m1(st_q.cfg.rx_thr_m1), .left(xfer_left),
        .ready(rx_ready), .drain(rx_drain)
    );

    level_flags #(.DEPTH(DEPTH), .IS_TX(1'b1), .CW(CW), .THR_W(THR_W)) u_txf (
        .level(tx_level), .thr_m1(st_q.cfg.tx_thr_m1), .left(xfer_left),
        .ready(tx_ready), .drain(tx_drain)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovr = rx_push_lost;
        st_d.udf = tx_pop_lost;
        if (cfg_wr) begin
            st_d.cfg.rx_dma    = cfg_wdata[CFG_RX_DMA];
            st_d.cfg.rx_thr_m1 = cfg_wdata[CFG_RX_THR +: THR_W];
            st_d.cfg.tx_dma    = cfg_wdata[CFG_TX_DMA];
            st_d.cfg.tx_thr_m1 = cfg_wdata[CFG_TX_THR +: THR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata    = {st_q.cfg.rx_dma, 1'b0, st_q.cfg.rx_thr_m1,
                           st_q.cfg.tx_dma, 1'b0, st_q.cfg.tx_thr_m1};
    assign stat_rdata   = {SZ, LVL_FIELD_W'(rx_level), LVL_FIELD_W'(tx_level)};
    assign rx_dma_req   = rx_ready && st_q.cfg.rx_dma;
    assign tx_dma_req   = tx_ready && st_q.cfg.tx_dma;
    assign rx_overrun   = st_q.ovr;
    assign tx_underflow = st_q.udf;

    AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full) |=> rx_overrun); // R10
    AST_UDF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_pop && tx_empty) |=> tx_underflow); // R11
    AST_RX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> rx_ready); // R8
    AST_TX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> tx_ready); // R8
    AST_RX_READY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (stat_rdata[13:7] != '0)); // R4
    AST_TX_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !tx_full); // R6
    AST_TX_DRAIN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drain |-> !tx_full); // R7
    AST_RX_FLUSH_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (stat_rdata[13:7] == '0)); // R9
endmodule

// File: tb/sim_fifo_pair_thr.sv
`timescale 1ns/1ps
module sim_fifo_pair_thr;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata, stat_rdata;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic [15:0] xfer_left = '0;
    logic        rx_ready, rx_drain, tx_ready, tx_drain;
    logic        rx_dma_req, tx_dma_req, rx_overrun, tx_underflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    fifo_pair_thr #(.SIZE_CODE(1), .CW(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .stat_rdata(stat_rdata), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .xfer_left(xfer_left), .rx_ready(rx_ready), .rx_drain(rx_drain),
        .tx_ready(tx_ready), .tx_drain(tx_drain), .rx_dma_req(rx_dma_req),
        .tx_dma_req(tx_dma_req), .rx_overrun(rx_overrun),
        .tx_underflow(tx_underflow)
    );

    // op codes
    localparam logic [3:0] OP_CFG = 0, OP_LEFT = 1, OP_RXP = 2, OP_TXW = 3,
                           OP_RXRD = 4, OP_TXPOP = 5, OP_STAT = 6, OP_FLAGS = 7;
    // entry: {op, req, arg, exp}; flags = {rxr, rxd, txr, txd, rxdma, txdma}
    localparam int NV = 31;
    localparam logic [39:0] VEC [NV] = '{
        {OP_FLAGS, 4'd4, 16'h0000, 16'h0000}, // R4 idle after reset
        {OP_STAT,  4'd1, 16'h0000, 16'h4000}, // R1
        {OP_CFG,   4'd2, 16'h8383, 16'h0000}, // R2 thr 4/4, DMA on
        {OP_LEFT,  4'd6, 16'd6,    16'h0000},
        {OP_FLAGS, 4'd6, 16'h0000, 16'h0009}, // R6 tx burst
        {OP_RXP,   4'd3, 16'h00A1, 16'h0000},
        {OP_RXP,   4'd3, 16'h00A2, 16'h0000},
        {OP_RXP,   4'd3, 16'h00A3, 16'h0000},
        {OP_FLAGS, 4'd4, 16'h0000, 16'h0009}, // R4 below threshold
        {OP_RXP,   4'd3, 16'h00A4, 16'h0000},
        {OP_FLAGS, 4'd8, 16'h0000, 16'h002B}, // R8 both DMA
        {OP_STAT,  4'd1, 16'h0000, 16'h4200}, // R1
        {OP_RXRD,  4'd3, 16'h0000, 16'h00A1}, // R3 order
        {OP_RXRD,  4'd3, 16'h0000, 16'h00A2},
        {OP_TXW,   4'd3, 16'h0011, 16'h0000},
        {OP_TXW,   4'd3, 16'h0022, 16'h0000},
        {OP_TXW,   4'd3, 16'h0033, 16'h0000},
        {OP_FLAGS, 4'd7, 16'h0000, 16'h0004}, // R7 tx residue
        {OP_LEFT,  4'd5, 16'd0,    16'h0000},
        {OP_FLAGS, 4'd5, 16'h0000, 16'h0010}, // R5 rx residue
        {OP_STAT,  4'd1, 16'h0000, 16'h4103}, // R1
        {OP_TXPOP, 4'd3, 16'h0000, 16'h0011},
        {OP_TXPOP, 4'd3, 16'h0000, 16'h0022},
        {OP_TXPOP, 4'd3, 16'h0000, 16'h0033},
        {OP_RXRD,  4'd3, 16'h0000, 16'h00A3},
        {OP_RXRD,  4'd3, 16'h0000, 16'h00A4},
        {OP_RXRD,  4'd3, 16'h0000, 16'h0000}, // R3 empty read gives 0
        {OP_STAT,  4'd3, 16'h0000, 16'h4000}, // R3 levels untouched
        {OP_CFG,   4'd8, 16'h0303, 16'h0000},
        {OP_LEFT,  4'd8, 16'd8,    16'h0000},
        {OP_FLAGS, 4'd8, 16'h0000, 16'h0008}  // R8 DMA gated off
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic rx_push(input logic [7:0] d);
        eng_rx_push = 1'b1; eng_rx_data = d; tick(); eng_rx_push = 1'b0;
    endtask
    task automatic tx_write(input logic [7:0] d);
        cpu_wr = 1'b1; cpu_wdata = d; tick(); cpu_wr = 1'b0;
    endtask
    task automatic cpu_read(output logic [7:0] d);
        cpu_rd = 1'b1; d = cpu_rdata; tick(); cpu_rd = 1'b0;
    endtask
    task automatic eng_pop(output logic [7:0] d);
        eng_tx_pop = 1'b1; d = eng_tx_data; tick(); eng_tx_pop = 1'b0;
    endtask
    task automatic cfg_write(input logic [15:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; tick(); cfg_wr = 1'b0;
    endtask

    function automatic logic [15:0] flags();
        return {10'd0, rx_ready, rx_drain, tx_ready, tx_drain, rx_dma_req, tx_dma_req};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // reset state
        chk("R1", stat_rdata, 16'h4000);
        chk("R2", cfg_rdata, 16'h0000);
        chk("R10", {15'd0, rx_overrun}, 16'h0);
        chk("R11", {15'd0, tx_underflow}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  op;
            logic [3:0]  rq;
            logic [15:0] arg, exp;
            string       tag;
            {op, rq, arg, exp} = VEC[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            case (op)
                OP_CFG:   cfg_write(arg);
                OP_LEFT:  begin xfer_left = arg; tick(); end
                OP_RXP:   rx_push(arg[7:0]);
                OP_TXW:   tx_write(arg[7:0]);
                OP_RXRD:  begin cpu_read(d); chk(tag, {8'd0, d}, exp); end
                OP_TXPOP: begin eng_pop(d);  chk(tag, {8'd0, d}, exp); end
                OP_STAT:  chk(tag, stat_rdata, exp);
                default:  chk(tag, flags(), exp);
            endcase
        end

        // R9 flush both queues, flush bits read back as 0 (R2)
        rx_push(8'h05); rx_push(8'h06); rx_push(8'h07);
        tx_write(8'h01); tx_write(8'h02);
        cfg_write(16'h4343);
        chk("R9", stat_rdata, 16'h4000);
        chk("R2", cfg_rdata, 16'h0303);

        // R9 flush wins over a push in the same cycle
        rx_push(8'h09);
        eng_rx_push = 1'b1; eng_rx_data = 8'h55; cfg_wr = 1'b1; cfg_wdata = 16'h4303;
        tick();
        eng_rx_push = 1'b0; cfg_wr = 1'b0;
        chk("R9", stat_rdata, 16'h4000);

        // R4 threshold above depth is clamped to depth
        cfg_write(16'h3F03);
        xfer_left = 16'd100;
        for (int i = 0; i < 15; i++) rx_push(8'h40 + 8'(i));
        chk("R4", {15'd0, rx_ready}, 16'h0);
        rx_push(8'h4F);
        chk("R4", {15'd0, rx_ready}, 16'h1);
        chk("R1", stat_rdata, 16'h4800);

        // R10 overrun pulse, byte dropped
        rx_push(8'hEE);
        chk("R10", {15'd0, rx_overrun}, 16'h1);
        chk("R10", stat_rdata, 16'h4800);
        tick();
        chk("R10", {15'd0, rx_overrun}, 16'h0);
        cpu_read(d);
        chk("R10", {8'd0, d}, 16'h0040);

        // R11 underflow on empty transmit pop
        cfg_write(16'h4303);
        eng_pop(d);
        chk("R11", {8'd0, d}, 16'h0000);
        chk("R11", {15'd0, tx_underflow}, 16'h1);
        tick();
        chk("R11", {15'd0, tx_underflow}, 16'h0);

        // R3 write to full transmit queue is discarded
        cfg_write(16'h0307);
        xfer_left = 16'd20;
        for (int i = 0; i < 16; i++) tx_write(8'h80 + 8'(i));
        tx_write(8'hFF);
        chk("R3", stat_rdata, 16'h4010);
        eng_pop(d);
        chk("R3", {8'd0, d}, 16'h0080);
        // R7 no drain when residue exceeds free room (need 5, free 1)
        chk("R7", flags(), 16'h0000);
        // R6 after flush: need 20, free 16, thr 8
        cfg_write(16'h0347);
        chk("R6", {15'd0, tx_ready}, 16'h1);
        chk("R8", {15'd0, tx_dma_req}, 16'h0);

        finish_run();
    end
endmodule